// File: doc/BRIEF.md
# Strobe-Driven Three-Lane I/O Port Unit

This unit sits beside a small 8-bit controller core and gives it three byte-wide I/O ports. The core steers the unit with one-cycle strobes: a direction-load strobe and an output-write strobe for each port, plus a read strobe for each port. All three kinds share one data bus from the core and one file address. The unit returns a single byte, and it picks that byte from the file address alone. Each port keeps a direction register, an output latch and a small input queue. Pin changes on the input side are synchronized, and each new value is queued.

A plain read of a port address raises that port's read strobe, which pops the queue head. A read-modify-write of the same address arrives with only the write strobe. In that case the core still sees the queue head on the return bus, but the head stays in place, so no input byte is lost. While a queue is empty, the return bus shows the port's live synchronized pin value.

Top module: `ioport_unit`

## Requirements
- R1: After reset every direction register holds 0xFF, so all `pin_oe` bits are 0. Every output latch reads 0 on `pin_out`, and every input queue is empty.
- R2: A direction-load strobe `dir_we[i]` with `clk_en` high loads `wr_data` into port i's direction register on that edge. Bit k of `pin_oe` for port i is then the inverse of direction bit k, so a 0 bit drives the pin.
- R3: An output-write strobe `out_we[i]` with `clk_en` high loads `wr_data` into port i's output latch on that edge, and the latch drives `pin_out` for port i. Port i uses bits [8i+7:8i] of `pin_out`, `pin_oe` and `pin_in`.
- R4: Any strobe that arrives while `clk_en` is low has no effect on any register or queue.
- R5: Port pins pass through a two-flop synchronizer. A changed synchronized value is pushed into that port's 4-entry queue on the third rising edge after the pin changes. A change seen while the queue is full is dropped.
- R6: A read strobe `rd_stb[i]` with `clk_en` high pops the head of port i's non-empty queue, so the next entry appears on `rd_data`.
- R7: An output-write strobe to a port address leaves that port's queue untouched, so its head stays on `rd_data`.
- R8: While a port's queue is empty, `rd_data` for that port shows its synchronized pin value, and a read strobe changes nothing.
- R9: `rd_data` is selected combinationally by `file_addr`: 5 gives port A (i=0), 6 gives port B (i=1), 7 gives port C (i=2), and any other address gives 0x00.
- R10: If a push and a pop fall on the same edge, the old head is removed and the new value is stored, so the entry count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Qualifies all strobes |
| dir_we | input | 3 | Direction-load strobe per port |
| out_we | input | 3 | Output-latch write strobe per port |
| rd_stb | input | 3 | Queue pop strobe per port |
| wr_data | input | 8 | Data from the core for latch and direction loads |
| file_addr | input | 5 | File address that selects the returned port |
| rd_data | output | 8 | Selected port's queue head or live pin value |
| pin_in | input | 24 | Asynchronous pin inputs, 8 per port |
| pin_out | output | 24 | Output-latch values, 8 per port |
| pin_oe | output | 24 | Pin drive enables, 8 per port |

## Verification
Two events can land on the same clock edge: a synchronized pin change entering a queue and a read strobe draining that queue. The bench provokes this by changing port B's pins, counting two edges for the synchronizer, and raising the read strobe just before the third edge, where the push occurs. The result is judged by what follows at the ports. The returned byte must be the new value. A later pin change must queue behind it rather than replace it, which shows that neither the push nor the pop was lost.

// File: rtl/ioport_pkg.sv
package ioport_pkg;
   function automatic int unsigned level_width(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction
   function automatic int unsigned ptr_width(input int unsigned depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction
endpackage

// File: rtl/ioport_infifo.sv
module ioport_infifo
   import ioport_pkg::*;
#(
   parameter int unsigned DW          = 8,
   parameter int unsigned DEPTH       = 4,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned CW = level_width(DEPTH),
   localparam int unsigned PW = ptr_width(DEPTH)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] pin_async,
   input  logic          pop,
   output logic [DW-1:0] view,
   output logic [CW-1:0] level
);
   logic [DW-1:0] sync_q [SYNC_STAGES];
   logic [DW-1:0] seen_q;
   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wp_q, rp_q;
   logic          push, do_pop;

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[s] <= '0;
            else if (s == 0) sync_q[s] <= pin_async;
            else sync_q[s] <= sync_q[(s > 0) ? s-1 : 0];
         end
      end
   endgenerate

   assign push   = (sync_q[SYNC_STAGES-1] != seen_q) && (level != CW'(DEPTH));
   assign do_pop = pop && (level != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q <= '0;
         wp_q   <= '0;
         rp_q   <= '0;
         level  <= '0;
      end else begin
         seen_q <= sync_q[SYNC_STAGES-1];
         if (push) wp_q <= (wp_q == PW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
         if (do_pop) rp_q <= (rp_q == PW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
         if (push && !do_pop) level <= level + 1'b1;
         else if (do_pop && !push) level <= level - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wp_q] <= sync_q[SYNC_STAGES-1];
   end

   assign view = (level == '0) ? sync_q[SYNC_STAGES-1] : mem[rp_q];
endmodule

// File: rtl/ioport_lane.sv
module ioport_lane
   import ioport_pkg::*;
#(
   parameter int unsigned DW          = 8,
   parameter int unsigned DEPTH       = 4,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned CW = level_width(DEPTH)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clk_en,
   input  logic          dir_we,
   input  logic          out_we,
   input  logic          rd_stb,
   input  logic [DW-1:0] wr_data,
   input  logic [DW-1:0] pins,
   output logic [DW-1:0] drive,
   output logic [DW-1:0] drive_en,
   output logic [DW-1:0] view,
   output logic [CW-1:0] level
);
   logic [DW-1:0] dir_q, lat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q <= '1;
         lat_q <= '0;
      end else if (clk_en) begin
         if (dir_we) dir_q <= wr_data;
         if (out_we) lat_q <= wr_data;
      end
   end

   assign drive    = lat_q;
   assign drive_en = ~dir_q;

   ioport_infifo #(.DW(DW), .DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) i_fifo (
      .clk(clk), .rst_n(rst_n), .pin_async(pins),
      .pop(clk_en && rd_stb), .view(view), .level(level)
   );
endmodule

// File: rtl/ioport_unit.sv
module ioport_unit
   import ioport_pkg::*;
#(
   parameter int unsigned NPORT       = 3,
   parameter int unsigned DW          = 8,
   parameter int unsigned DEPTH       = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned AW          = 5,
   parameter int unsigned BASE_ADDR   = 5,
   localparam int unsigned CW = level_width(DEPTH)
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clk_en,
   input  logic [NPORT-1:0]    dir_we,
   input  logic [NPORT-1:0]    out_we,
   input  logic [NPORT-1:0]    rd_stb,
   input  logic [DW-1:0]       wr_data,
   input  logic [AW-1:0]       file_addr,
   output logic [DW-1:0]       rd_data,
   input  logic [NPORT*DW-1:0] pin_in,
   output logic [NPORT*DW-1:0] pin_out,
   output logic [NPORT*DW-1:0] pin_oe
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
         $error("ioport_unit: DEPTH must be a power of two of at least 2");
      if (SYNC_STAGES < 2)
         $error("ioport_unit: SYNC_STAGES must be at least 2");
      if (BASE_ADDR + NPORT > (1 << AW))
         $error("ioport_unit: port addresses exceed the address space");
   endgenerate

   logic [DW-1:0]       view [NPORT];
   logic [NPORT*CW-1:0] fifo_level;

   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_lane
         ioport_lane #(.DW(DW), .DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) i_lane (
            .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
            .dir_we(dir_we[p]), .out_we(out_we[p]), .rd_stb(rd_stb[p]),
            .wr_data(wr_data), .pins(pin_in[p*DW +: DW]),
            .drive(pin_out[p*DW +: DW]), .drive_en(pin_oe[p*DW +: DW]),
            .view(view[p]), .level(fifo_level[p*CW +: CW])
         );
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int p = 0; p < NPORT; p++)
         if (file_addr == AW'(BASE_ADDR + p)) rd_data = view[p];
   end
endmodule

// File: rtl/ioport_unit_chk.sv
module ioport_unit_chk #(
   parameter int unsigned NPORT = 3,
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 4,
   parameter int unsigned CW    = 3
)(
   input logic                clk,
   input logic                rst_n,
   input logic                clk_en,
   input logic [NPORT-1:0]    dir_we,
   input logic [NPORT-1:0]    out_we,
   input logic [NPORT-1:0]    rd_stb,
   input logic [NPORT*DW-1:0] pin_out,
   input logic [NPORT*DW-1:0] pin_oe,
   input logic [NPORT*CW-1:0] fifo_level
);
   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_chk
         assert_oe_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !(clk_en && dir_we[p]) |=> $stable(pin_oe[p*DW +: DW]));
         assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !(clk_en && out_we[p]) |=> $stable(pin_out[p*DW +: DW]));
         assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
            fifo_level[p*CW +: CW] <= CW'(DEPTH));
         // R4 R7: a queue only drains after a qualified read strobe
         assert_pop_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !(clk_en && rd_stb[p]) |=> fifo_level[p*CW +: CW] >= $past(fifo_level[p*CW +: CW]));
      end
   endgenerate
endmodule

bind ioport_unit ioport_unit_chk #(.NPORT(NPORT), .DW(DW), .DEPTH(DEPTH), .CW(CW)) i_chk (
   .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .dir_we(dir_we), .out_we(out_we),
   .rd_stb(rd_stb), .pin_out(pin_out), .pin_oe(pin_oe), .fifo_level(fifo_level)
);

// File: tb/test_ioport_unit.sv
module test_ioport_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 0, rst_n = 0, clk_en = 1;
   logic [2:0]  dir_we = 0, out_we = 0, rd_stb = 0;
   logic [7:0]  wr_data = 0;
   logic [4:0]  file_addr = 0;
   logic [7:0]  rd_data;
   logic [23:0] pin_in = 0, pin_out, pin_oe;
   int checks = 0, failures = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ioport_unit i_ioport_unit (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .dir_we(dir_we), .out_we(out_we),
      .rd_stb(rd_stb), .wr_data(wr_data), .file_addr(file_addr), .rd_data(rd_data),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic tick(input int n = 1);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic read_at(input logic [4:0] a, input string req, input logic [7:0] exp);
      file_addr = a; #1;
      check(req, rd_data, exp);
   endtask

   task automatic strobe(input int kind, input int port, input logic [7:0] d);
      wr_data = d;
      case (kind)
         0: dir_we[port] = 1;
         1: out_we[port] = 1;
         default: rd_stb[port] = 1;
      endcase
      tick();
      dir_we = 0; out_we = 0; rd_stb = 0;
   endtask

   task automatic t_reset;
      check("R1 oe", pin_oe, 24'h0);
      check("R1 out", pin_out, 24'h0);
      read_at(5'd5, "R1 rd", 8'h00);
   endtask

   task automatic t_dir_out;
      strobe(0, 0, 8'h0F);
      check("R2 oe A", pin_oe, 24'h0000F0);
      strobe(1, 2, 8'hA5);
      check("R3 out C", pin_out, 24'hA50000);
      clk_en = 0;
      strobe(0, 1, 8'h00);
      strobe(1, 0, 8'h77);
      clk_en = 1;
      check("R4 oe", pin_oe, 24'h0000F0);
      check("R4 out", pin_out, 24'hA50000);
   endtask

   task automatic t_fill_drain;
      for (int v = 1; v <= 5; v++) begin
         pin_in[7:0] = 8'(v);
         tick(4);
      end
      read_at(5'd5, "R5 head after fill", 8'h01);
      strobe(2, 0, 0);
      read_at(5'd5, "R6 pop", 8'h02);
      strobe(1, 0, 8'h3C);
      read_at(5'd5, "R7 rmw keeps head", 8'h02);
      check("R7 latch", pin_out[7:0], 8'h3C);
      clk_en = 0;
      strobe(2, 0, 0);
      clk_en = 1;
      read_at(5'd5, "R4 pop ignored", 8'h02);
      strobe(2, 0, 0);
      read_at(5'd5, "R6 pop 3", 8'h03);
      strobe(2, 0, 0);
      read_at(5'd5, "R5 fifth dropped", 8'h04);
      strobe(2, 0, 0);
      read_at(5'd5, "R8 empty shows pins", 8'h05);
      strobe(2, 0, 0);
      read_at(5'd5, "R8 empty pop no effect", 8'h05);
   endtask

   task automatic t_mux;
      pin_in[15:8] = 8'h11; pin_in[23:16] = 8'hC3;
      tick(4);
      read_at(5'd6, "R9 port B", 8'h11);
      read_at(5'd7, "R9 port C", 8'hC3);
      read_at(5'd4, "R9 unmapped", 8'h00);
      read_at(5'd8, "R9 unmapped hi", 8'h00);
   endtask

   task automatic t_same_edge;
      pin_in[15:8] = 8'h22;
      tick(2);
      rd_stb[1] = 1;
      tick();
      rd_stb = 0;
      read_at(5'd6, "R10 new value after push+pop", 8'h22);
      pin_in[15:8] = 8'h33;
      tick(4);
      read_at(5'd6, "R10 count kept", 8'h22);
      strobe(2, 1, 0);
      read_at(5'd6, "R10 next", 8'h33);
   endtask

   initial begin
      tick(3);
      rst_n = 1;
      tick();
      t_reset();
      t_dir_out();
      t_fill_drain();
      t_mux();
      t_same_edge();
      done = 1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule